// File: doc/BRIEF.md
# Pipelined address bus cycle sequencer

This block is the master side of a processor-style local bus. It accepts one internal transfer request at a time (word address, byte enables, direction, write data), holds it in a one-entry slot, and runs it on the bus as a sequence of bus states. Each bus state is two clock periods long: phase one, then phase two. A slave ends a cycle with the acknowledge input `ack_i`, which is sampled at the end of phase two. The slave may also raise `pipe_ok_i` to let the master put the next cycle's address out before the current cycle ends. This input is sampled at the end of phase one.

A cycle that starts from idle is never overlapped. It runs an address state followed by one or more data states. If `pipe_ok_i` is seen in a data wait state while a request is held, the block moves into an overlap state. In that state the next cycle's address and direction are on the bus while the current cycle's data phase continues. The acknowledge then starts the next cycle directly in a pipelined-address state. From there, back-to-back cycles of only two states can be sustained. Completed cycles are reported in order with a one-clock pulse, together with any captured read data.

State codes on `state_o`: 0 idle, 1 address, 2 data, 3 pipelined address, 4 overlap.

Top module: `pipe_bus_seq`

## Requirements
- R1: After reset the state is idle (code 0), `data_oe_o` and `done_o` are low, and `req_ready_o` is high.
- R2: Every bus state lasts exactly two clocks. A held request in idle leads to an address state (1) and then a data state (2). From the address state onward, `addr_o`, `be_o` and `wr_o` show that request.
- R3: `pipe_ok_i` is ignored in the address state. If the acknowledge comes in the first data state (no wait state), the following cycle starts with a non-pipelined address state (1), even when `pipe_ok_i` was high.
- R4: If `pipe_ok_i` is sampled high in a data state that does not end with an acknowledge, and a request is held, the next state is overlap (4) and `addr_o` shows the next request. Overlap repeats until an acknowledge, which leads to a pipelined-address state (3).
- R5: The acknowledge is honoured only at the end of phase two of a data (2) or overlap (4) state. A high `ack_i` in the address, pipelined-address or phase-one windows has no effect.
- R6: If `pipe_ok_i` is high but no request is held, the cycle stays in data states until the acknowledge, then returns to idle.
- R7: In a pipelined-address state, `pipe_ok_i` high with a request held leads to overlap (4). Without both it leads to a data state (2), where pipelining can still be entered.
- R8: For a write, `data_oe_o` is high and `data_o` carries the write data from phase two of the cycle's first state until its acknowledge. It is low for reads and in idle.
- R9: `done_o` pulses for one clock right after each acknowledged cycle, in bus order. For a read, `rdata_o` then holds the `data_i` value sampled with the acknowledge.
- R10: `req_ready_o` drops the clock after a request is accepted and stays low until that request's address is put on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, two periods per bus state |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Internal request offered |
| req_ready_o | output | 1 | Request slot empty |
| req_addr_i | input | ADDR_W | Request word address |
| req_be_i | input | DATA_W/8 | Request byte enables |
| req_wr_i | input | 1 | Request is a write |
| req_wdata_i | input | DATA_W | Request write data |
| pipe_ok_i | input | 1 | Slave allows early next address |
| ack_i | input | 1 | Slave ends the current cycle |
| data_i | input | DATA_W | Read data from the bus |
| addr_o | output | ADDR_W | Bus address |
| be_o | output | DATA_W/8 | Bus byte enables |
| wr_o | output | 1 | Cycle definition: write when high |
| data_o | output | DATA_W | Write data toward the bus |
| data_oe_o | output | 1 | Drive enable for `data_o` |
| state_o | output | 3 | Current bus state code |
| done_o | output | 1 | Cycle completed pulse |
| rdata_o | output | DATA_W | Last captured read data |

## Verification
The acknowledge that closes one cycle and the launch of the next address can fall on the same clock edge. This happens both from a data state without a wait state, which must start a plain address state, and from overlap, which must start a pipelined-address state. The stimulus tables provoke both. They raise `pipe_ok_i` and `ack_i` together in a first data state and in pipelined-address states where the acknowledge must be ignored. Each run is judged from the state code, the address and the data-drive enable seen in each phase, and from the order and contents of the completion pulses.

// File: rtl/pipe_seq_pkg.sv
package pipe_seq_pkg;

  typedef enum logic [2:0] {
    BS_IDLE  = 3'd0,
    BS_ADDR  = 3'd1,
    BS_DATA  = 3'd2,
    BS_PADDR = 3'd3,
    BS_PDATA = 3'd4
  } bus_state_e;

  // address has been stable for a full state and only one cycle is queued
  function automatic logic pipe_window(bus_state_e s);
    return (s == BS_DATA) || (s == BS_PADDR);
  endfunction

  function automatic logic ack_window(bus_state_e s);
    return (s == BS_DATA) || (s == BS_PDATA);
  endfunction

endpackage

// File: rtl/pipe_phase_gen.sv
module pipe_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ph2_o
);

  logic ph2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph2_q <= 1'b0;
    else         ph2_q <= ~ph2_q;
  end

  assign ph2_o = ph2_q;

endmodule

// File: rtl/pipe_req_slot.sv
module pipe_req_slot #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [WIDTH-1:0] in_data_i,
  output logic             in_ready_o,
  input  logic             take_i,
  output logic             full_o,
  output logic [WIDTH-1:0] data_o
);

  logic             full_q;
  logic [WIDTH-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= in_data_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign in_ready_o = ~full_q;
  assign full_o     = full_q;
  assign data_o     = data_q;

endmodule

// File: rtl/pipe_bus_fsm.sv
module pipe_bus_fsm
  import pipe_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ph2_i,
  input  logic       pipe_ok_i,
  input  logic       ack_i,
  input  logic       pend_i,
  output bus_state_e state_o,
  output logic       launch_o,
  output logic       start_o,
  output logic       cyc_end_o
);

  bus_state_e state_q, state_d;
  logic       pipe_hit_q;
  logic       launch, start, cyc_end;

  always_comb begin
    state_d = state_q;
    launch  = 1'b0;
    start   = 1'b0;
    cyc_end = 1'b0;
    if (ph2_i) begin
      unique case (state_q)
        BS_IDLE: begin
          if (pend_i) begin
            state_d = BS_ADDR;
            launch  = 1'b1;
            start   = 1'b1;
          end
        end
        BS_ADDR: state_d = BS_DATA;
        BS_DATA: begin
          if (ack_i) begin
            cyc_end = 1'b1;
            if (pend_i) begin
              state_d = BS_ADDR;
              launch  = 1'b1;
              start   = 1'b1;
            end else begin
              state_d = BS_IDLE;
            end
          end else if (pipe_hit_q && pend_i) begin
            state_d = BS_PDATA;
            launch  = 1'b1;
          end
        end
        BS_PADDR: begin
          if (pipe_hit_q && pend_i) begin
            state_d = BS_PDATA;
            launch  = 1'b1;
          end else begin
            state_d = BS_DATA;
          end
        end
        BS_PDATA: begin
          if (ack_i) begin
            cyc_end = 1'b1;
            start   = 1'b1;
            state_d = BS_PADDR;
          end
        end
        default: state_d = BS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= BS_IDLE;
      pipe_hit_q <= 1'b0;
    end else begin
      state_q <= state_d;
      // sticky within one cycle, sampled at end of phase one only
      if (cyc_end)
        pipe_hit_q <= 1'b0;
      else if (!ph2_i && pipe_window(state_q) && pipe_ok_i)
        pipe_hit_q <= 1'b1;
    end
  end

  assign state_o   = state_q;
  assign launch_o  = launch;
  assign start_o   = start;
  assign cyc_end_o = cyc_end;

endmodule

// File: rtl/pipe_bus_seq.sv
module pipe_bus_seq
  import pipe_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  input  logic                req_wr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic                pipe_ok_i,
  input  logic                ack_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W/8-1:0] be_o,
  output logic                wr_o,
  output logic [DATA_W-1:0]   data_o,
  output logic                data_oe_o,
  output logic [2:0]          state_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   rdata_o
);

  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned SLOT_W = ADDR_W + BE_W + 1 + DATA_W;

  logic              ph2;
  logic              slot_full;
  logic [SLOT_W-1:0] slot_q;
  logic              launch, start, cyc_end;
  bus_state_e        state;

  logic [ADDR_W-1:0] s_addr;
  logic [BE_W-1:0]   s_be;
  logic              s_wr;
  logic [DATA_W-1:0] s_wdata;

  // address stage: what the address pins show
  logic [ADDR_W-1:0] a_addr_q;
  logic [BE_W-1:0]   a_be_q;
  logic              a_wr_q;
  logic [DATA_W-1:0] a_wdata_q;
  // data stage: the cycle whose data phase is running
  logic              d_wr_q;
  logic [DATA_W-1:0] d_wdata_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  pipe_phase_gen u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ph2_o  (ph2)
  );

  pipe_req_slot #(.WIDTH(SLOT_W)) u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (req_valid_i),
    .in_data_i  ({req_addr_i, req_be_i, req_wr_i, req_wdata_i}),
    .in_ready_o (req_ready_o),
    .take_i     (launch),
    .full_o     (slot_full),
    .data_o     (slot_q)
  );

  pipe_bus_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ph2_i     (ph2),
    .pipe_ok_i (pipe_ok_i),
    .ack_i     (ack_i),
    .pend_i    (slot_full),
    .state_o   (state),
    .launch_o  (launch),
    .start_o   (start),
    .cyc_end_o (cyc_end)
  );

  assign {s_addr, s_be, s_wr, s_wdata} = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_addr_q  <= '0;
      a_be_q    <= '0;
      a_wr_q    <= 1'b0;
      a_wdata_q <= '0;
    end else if (launch) begin
      a_addr_q  <= s_addr;
      a_be_q    <= s_be;
      a_wr_q    <= s_wr;
      a_wdata_q <= s_wdata;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_wr_q    <= 1'b0;
      d_wdata_q <= '0;
    end else if (start) begin
      // non-pipelined start loads straight from the slot
      d_wr_q    <= launch ? s_wr    : a_wr_q;
      d_wdata_q <= launch ? s_wdata : a_wdata_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= cyc_end;
      if (cyc_end && !d_wr_q) rdata_q <= data_i;
    end
  end

  assign addr_o    = a_addr_q;
  assign be_o      = a_be_q;
  assign wr_o      = a_wr_q;
  assign data_o    = d_wdata_q;
  assign data_oe_o = d_wr_q && (ack_window(state) ||
                                (ph2 && (state == BS_ADDR || state == BS_PADDR)));
  assign state_o   = state;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;

endmodule

// File: rtl/pipe_bus_seq_chk.sv
module pipe_bus_seq_chk
  import pipe_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ph2_i,
  input logic [2:0] state_i,
  input logic       ack_i,
  input logic       data_oe_i,
  input logic       done_i,
  input logic       req_valid_i,
  input logic       req_ready_i
);

  // R2
  hold_in_phase_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph2_i |=> $stable(state_i));

  // R2
  addr_to_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == BS_ADDR && ph2_i) |=> state_i == BS_DATA);

  // R3
  addr_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == BS_ADDR && $past(state_i) != BS_ADDR) |->
      ($past(state_i) == BS_IDLE || $past(state_i) == BS_DATA));

  // R4
  overlap_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == BS_PDATA && $past(state_i) != BS_PDATA) |->
      ($past(state_i) == BS_DATA || $past(state_i) == BS_PADDR));

  // R4
  paddr_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == BS_PADDR && $past(state_i) != BS_PADDR) |-> $past(state_i) == BS_PDATA);

  // R5
  overlap_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_i) == BS_PDATA && state_i != BS_PDATA) |-> ($past(ack_i) && $past(ph2_i)));

  // R8
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == BS_IDLE |-> !data_oe_i);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R9
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(ack_i));

  // R10
  slot_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_i) |=> !req_ready_i);

endmodule

bind pipe_bus_seq pipe_bus_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ph2_i       (ph2),
  .state_i     (state_o),
  .ack_i       (ack_i),
  .data_oe_i   (data_oe_o),
  .done_i      (done_o),
  .req_valid_i (req_valid_i),
  .req_ready_i (req_ready_o)
);

// File: tb/tb_pipe_bus_seq.sv
`timescale 1ns/1ps
module tb_pipe_bus_seq;

  localparam int ADDR_W = 30;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int NS     = 12;
  localparam int NV     = 5;

  localparam logic [2:0] S_I = 3'd0, S_A = 3'd1, S_B = 3'd2, S_C = 3'd3, S_D = 3'd4;
  localparam logic [2:0] X = 3'd7;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [BE_W-1:0]   req_be_i = '0;
  logic              req_wr_i = 1'b0;
  logic [DATA_W-1:0] req_wdata_i = '0;
  logic              pipe_ok_i = 1'b0;
  logic              ack_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic [BE_W-1:0]   be_o;
  logic              wr_o;
  logic [DATA_W-1:0] data_o;
  logic              data_oe_o;
  logic [2:0]        state_o;
  logic              done_o;
  logic [DATA_W-1:0] rdata_o;

  pipe_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_be_i(req_be_i), .req_wr_i(req_wr_i),
    .req_wdata_i(req_wdata_i), .pipe_ok_i(pipe_ok_i), .ack_i(ack_i),
    .data_i(data_i), .addr_o(addr_o), .be_o(be_o), .wr_o(wr_o),
    .data_o(data_o), .data_oe_o(data_oe_o), .state_o(state_o),
    .done_o(done_o), .rdata_o(rdata_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] rq_addr(int i);
    return ADDR_W'(32'h1000 + i);
  endfunction
  function automatic logic [BE_W-1:0] rq_be(int i);
    return BE_W'(1 << (i % BE_W));
  endfunction
  function automatic logic [DATA_W-1:0] rq_wdata(int i);
    return DATA_W'(32'hC0DE_0000 + i);
  endfunction
  function automatic logic [DATA_W-1:0] slv_data(int i);
    return DATA_W'(32'hA500_0000 + i);
  endfunction

  // one row per scenario: per bus state k the slave inputs and the expected
  // state code and index of the request on the address pins
  typedef struct packed {
    logic [3:0]            n_req;
    logic [7:0]            wr_mask;
    logic [3:0]            n_st;
    logic [0:NS-1]         pok;
    logic [0:NS-1]         ack;
    logic [0:NS-1][2:0]    st;
    logic [0:NS-1][2:0]    ai;
  } vec_t;

  localparam vec_t VECS [0:NV-1] = '{
    // single read, one wait state
    '{n_req:4'd1, wr_mask:8'h00, n_st:4'd5,
      pok:12'b000000000000, ack:12'b000100000000,
      st:'{S_I,S_A,S_B,S_B,S_I,S_I,S_I,S_I,S_I,S_I,S_I,S_I},
      ai:'{X,3'd0,3'd0,3'd0,X,X,X,X,X,X,X,X}},
    // no wait state: early-address permission has no effect
    '{n_req:4'd2, wr_mask:8'h01, n_st:4'd6,
      pok:12'b011110000000, ack:12'b001010000000,
      st:'{S_I,S_A,S_B,S_A,S_B,S_I,S_I,S_I,S_I,S_I,S_I,S_I},
      ai:'{X,3'd0,3'd0,3'd1,3'd1,X,X,X,X,X,X,X}},
    // transition then sustained two-state pipelined cycles
    '{n_req:4'd4, wr_mask:8'h05, n_st:4'd12,
      pok:12'b001001010100, ack:12'b010011101010,
      st:'{S_I,S_A,S_B,S_D,S_D,S_C,S_D,S_C,S_D,S_C,S_B,S_I},
      ai:'{X,3'd0,3'd0,3'd1,3'd1,3'd1,3'd2,3'd2,3'd3,3'd3,3'd3,X}},
    // permission without a held request
    '{n_req:4'd1, wr_mask:8'h01, n_st:4'd6,
      pok:12'b001100000000, ack:12'b000010000000,
      st:'{S_I,S_A,S_B,S_B,S_B,S_I,S_I,S_I,S_I,S_I,S_I,S_I},
      ai:'{X,3'd0,3'd0,3'd0,3'd0,X,X,X,X,X,X,X}},
    // pipelined start without permission falls back to data state
    '{n_req:4'd3, wr_mask:8'h02, n_st:4'd10,
      pok:12'b001001000000, ack:12'b000100101000,
      st:'{S_I,S_A,S_B,S_D,S_C,S_B,S_D,S_C,S_B,S_I,S_I,S_I},
      ai:'{X,3'd0,3'd0,3'd1,3'd1,3'd1,3'd2,3'd2,3'd2,X,X,X}}
  };

  localparam string VTAG [0:NV-1] = '{"R2", "R3", "R7", "R6", "R4"};

  task automatic do_reset();
    rst_ni = 1'b0;
    pipe_ok_i = 1'b0;
    ack_i = 1'b0;
    req_valid_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic feed(int m, logic [7:0] wm);
    for (int i = 0; i < m; i++) begin
      while (!req_ready_o) @(negedge clk);
      req_valid_i = 1'b1;
      req_addr_i  = rq_addr(i);
      req_be_i    = rq_be(i);
      req_wr_i    = wm[i];
      req_wdata_i = rq_wdata(i);
      @(negedge clk);
      req_valid_i = 1'b0;
    end
  endtask

  task automatic walk(vec_t v, string tag);
    int  pcur = 0;
    bit  pwr  = 1'b0;
    for (int k = 0; k < int'(v.n_st); k++) begin
      int cur;
      bit wr;
      bit exp_done;
      cur = (v.st[k] == S_D) ? int'(v.ai[k]) - 1 : int'(v.ai[k]);
      wr  = (v.st[k] != S_I) ? v.wr_mask[cur[2:0]] : 1'b0;
      // phase one of state k
      chk(tag, "state", 64'(state_o), 64'(v.st[k]));
      if (v.ai[k] != X) begin
        chk("R2", "addr", 64'(addr_o), 64'(rq_addr(int'(v.ai[k]))));
        chk("R2", "be", 64'(be_o), 64'(rq_be(int'(v.ai[k]))));
        chk("R4", "wr", 64'(wr_o), 64'(v.wr_mask[v.ai[k]]));
      end
      chk("R8", "oe ph1", 64'(data_oe_o), 64'(wr && (v.st[k] == S_B || v.st[k] == S_D)));
      exp_done = (k > 0) && v.ack[k-1] && (v.st[k-1] == S_B || v.st[k-1] == S_D);
      chk("R9", "done", 64'(done_o), 64'(exp_done));
      if (exp_done && !pwr)
        chk("R9", "rdata", 64'(rdata_o), 64'(slv_data(pcur)));
      pipe_ok_i = v.pok[k];
      ack_i     = v.ack[k];
      data_i    = slv_data(cur);
      @(posedge clk);
      @(negedge clk);
      // phase two of state k
      chk("R8", "oe ph2", 64'(data_oe_o), 64'(wr));
      if (wr) chk("R8", "wdata", 64'(data_o), 64'(rq_wdata(cur)));
      chk("R5", "state ph2", 64'(state_o), 64'(v.st[k]));
      pcur = cur;
      pwr  = wr;
      @(posedge clk);
      @(negedge clk);
    end
    pipe_ok_i = 1'b0;
    ack_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1", "state", 64'(state_o), 64'(S_I));
    chk("R1", "oe", 64'(data_oe_o), 64'd0);
    chk("R1", "done", 64'(done_o), 64'd0);
    chk("R1", "req_ready", 64'(req_ready_o), 64'd1);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      fork
        feed(int'(VECS[v].n_req), VECS[v].wr_mask);
        walk(VECS[v], VTAG[v]);
      join
    end

    // R10 slot, R5 acknowledge outside its window
    do_reset();
    req_valid_i = 1'b1;
    req_addr_i  = rq_addr(9);
    req_be_i    = rq_be(9);
    req_wr_i    = 1'b0;
    req_wdata_i = rq_wdata(9);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R10", "req_ready held", 64'(req_ready_o), 64'd0);
    chk("R10", "state idle ph2", 64'(state_o), 64'(S_I));
    @(posedge clk);
    @(negedge clk);
    chk("R2", "state addr", 64'(state_o), 64'(S_A));
    chk("R10", "req_ready after launch", 64'(req_ready_o), 64'd1);
    ack_i = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R5", "ack in addr state", 64'(state_o), 64'(S_B));
    @(posedge clk);
    @(negedge clk);
    ack_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R5", "ack in phase one only", 64'(state_o), 64'(S_B));
    chk("R5", "no done", 64'(done_o), 64'd0);
    ack_i  = 1'b1;
    data_i = 32'h5A5A_0001;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    ack_i = 1'b0;
    chk("R6", "back to idle", 64'(state_o), 64'(S_I));
    chk("R9", "done", 64'(done_o), 64'd1);
    chk("R9", "rdata", 64'(rdata_o), 64'h5A5A_0001);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "done one clock", 64'(done_o), 64'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule